// File: doc/BRIEF.md
# Exception Control Coprocessor

This unit sits beside the integer pipeline of a 32-bit load/store processor and owns the three registers that exception handling needs. The first is a status register, which holds an interrupt enable, an exception level flag and a user-mode flag. The second is a cause register, which holds a 5-bit exception code. The third is an exception program counter (EPC). The pipeline presents up to five synchronous fault requests and one interrupt line, together with the PC of the instruction in question.

The unit picks one request in the same cycle and asserts a redirect towards the single fixed handler entry at 0x80000180. At the next clock edge it records the code and the PC, and it raises the exception level. The raised level puts the processor in privileged mode and blocks further interrupts.

A return request redirects fetch to the saved EPC and drops the exception level. The core reads and writes the registers through a move-to port, which is clocked, and a move-from port, which is combinational. Both ports are addressed by a 5-bit register selector.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the status register reads 0x00000002 (exception level set), cause and EPC read 0, the privilege output is 1 and redirect is 0.
- R2: In any cycle where an exception is accepted, redirect is 1 and the redirect target is 0x80000180 in that same cycle.
- R3: After an accepted exception, the cause register holds the winning code in bits 6:2 and zero in every other bit. The codes are: interrupt 0, load address error 4, store address error 5, system call 8, reserved instruction 10, arithmetic overflow 12.
- R4: The fault PC presented in the accepting cycle is stored in the EPC at that cycle's clock edge and reads back on the following cycle.
- R5: Exception entry sets status bit 1 (exception level) and leaves the other status bits unchanged; the privilege output is 1 afterwards.
- R6: Among simultaneous requests the one with the lowest exception code is recorded.
- R7: The interrupt line is accepted only when status bit 0 (interrupt enable) is 1 and status bit 1 is 0. Otherwise it produces no redirect and leaves cause, EPC and status unchanged.
- R8: A return request with no accepted exception redirects to the current EPC in the same cycle and clears status bit 1 at the clock edge. If an exception is accepted in the same cycle, the exception wins and the return is discarded.
- R9: Move-to writes land at the clock edge and show on the move-from port in the next cycle. Selector 12 is status, of which only bits 0, 1 and 4 are writable and the rest read 0. Selector 13 is cause, of which only bits 6:2 are writable. Selector 14 is the EPC, which is fully writable. Any other selector reads 0.
- R10: A move-to write in a cycle where an exception is accepted, or a return is taken, is discarded; the hardware update stands.
- R11: The privilege output is 1 when status bit 1 is set or status bit 4 (user mode) is clear, and 0 only when bit 4 is 1 and bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Interrupt request level |
| exc_req_i | input | 5 | Fault requests: bit0 load address, bit1 store address, bit2 syscall, bit3 reserved instruction, bit4 overflow |
| fault_pc_i | input | 32 | PC of the instruction raising the request |
| eret_i | input | 1 | Return-from-exception request |
| mt_en_i | input | 1 | Move-to write strobe |
| mt_sel_i | input | 5 | Move-to register selector |
| mt_data_i | input | 32 | Move-to write data |
| mf_sel_i | input | 5 | Move-from register selector |
| mf_data_o | output | 32 | Move-from read data (combinational) |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |
| priv_o | output | 1 | 1 = privileged mode, 0 = user mode |

## Verification
The redirect strobe and its target are combinational, so they are due in the same cycle as the request. The bench drives inputs just after a falling edge and samples them one nanosecond later, before the next rising edge. Cause, EPC, status and the privilege output change at the rising edge that closes the accepting cycle. The bench therefore reads them through the move-from port in the cycle after, once the inputs have been returned to idle. Dropped writes and masked interrupts are checked in that same cycle, by reading back every register they could have disturbed.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int unsigned CODE_W    = 5;
   localparam int unsigned CAUSE_LSB = 2;
   localparam int unsigned IE_BIT    = 0;
   localparam int unsigned EXL_BIT   = 1;
   localparam int unsigned UM_BIT    = 4;
   localparam int unsigned NSRC      = 6;

   typedef enum logic [CODE_W-1:0] {
      EC_INT   = 5'd0,
      EC_ADEL  = 5'd4,
      EC_ADES  = 5'd5,
      EC_SYS   = 5'd8,
      EC_RSVD  = 5'd10,
      EC_OVF   = 5'd12
   } exc_code_e;

   // Source slot 0 is the qualified interrupt, slots 1..5 follow the fault
   // request bits. Slots must be listed in ascending code order.
   function automatic logic [CODE_W-1:0] src_code(input int unsigned idx);
      case (idx)
         0:       src_code = EC_INT;
         1:       src_code = EC_ADEL;
         2:       src_code = EC_ADES;
         3:       src_code = EC_SYS;
         4:       src_code = EC_RSVD;
         default: src_code = EC_OVF;
      endcase
   endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
   import exc_pkg::*;
#(
   parameter int unsigned N = NSRC
) (
   input  logic [N-1:0]      req_i,
   output logic              hit_o,
   output logic [CODE_W-1:0] code_o
);

   logic [N-1:0] win;

   // elaboration check: slots must have strictly rising codes so that the
   // lowest slot index is also the lowest code
   for (genvar i = 1; i < N; i++) begin : g_order
      if (src_code(i) <= src_code(i-1)) begin : g_bad
         $error("exc_prio: source codes not ascending");
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_win
      if (i == 0) begin : g_first
         assign win[i] = req_i[i];
      end else begin : g_rest
         assign win[i] = req_i[i] & ~(|req_i[i-1:0]);
      end
   end

   always_comb begin
      code_o = '0;
      for (int i = 0; i < N; i++) begin
         if (win[i]) code_o = code_o | src_code(i);
      end
   end

   assign hit_o = |req_i;

endmodule

// File: rtl/exc_csr_regs.sv
module exc_csr_regs
   import exc_pkg::*;
#(
   parameter int unsigned          XLEN         = 32,
   parameter int unsigned          SEL_W        = 5,
   parameter int unsigned          SEL_STATUS   = 12,
   parameter int unsigned          SEL_CAUSE    = 13,
   parameter int unsigned          SEL_EPC      = 14,
   parameter logic [XLEN-1:0]      RST_STATUS   = 32'h0000_0002,
   parameter logic [XLEN-1:0]      STATUS_WMASK = 32'h0000_0013
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [XLEN-1:0]   fault_pc_i,
   input  logic              eret_i,
   input  logic              wr_en_i,
   input  logic [SEL_W-1:0]  wr_sel_i,
   input  logic [XLEN-1:0]   wr_data_i,
   output logic [XLEN-1:0]   status_o,
   output logic [XLEN-1:0]   cause_o,
   output logic [XLEN-1:0]   epc_o
);

   localparam logic [SEL_W-1:0] S_STATUS = SEL_W'(SEL_STATUS);
   localparam logic [SEL_W-1:0] S_CAUSE  = SEL_W'(SEL_CAUSE);
   localparam logic [SEL_W-1:0] S_EPC    = SEL_W'(SEL_EPC);
   localparam int unsigned      CODE_HI  = CAUSE_LSB + CODE_W;

   if ((RST_STATUS & ~STATUS_WMASK) != '0) begin : g_chk_rst
      $error("exc_csr_regs: reset status sets a read-only bit");
   end
   if (STATUS_WMASK[EXL_BIT] != 1'b1) begin : g_chk_exl
      $error("exc_csr_regs: exception level bit must be storage");
   end
   if (XLEN < CODE_HI) begin : g_chk_w
      $error("exc_csr_regs: XLEN too small for cause field");
   end

   logic hw_busy;
   logic st_wr, ca_wr, ep_wr;

   assign hw_busy = take_i | eret_i;
   assign st_wr   = wr_en_i & ~hw_busy & (wr_sel_i == S_STATUS);
   assign ca_wr   = wr_en_i & ~hw_busy & (wr_sel_i == S_CAUSE);
   assign ep_wr   = wr_en_i & ~hw_busy & (wr_sel_i == S_EPC);

   // status: one flop per writable bit, constant otherwise
   for (genvar b = 0; b < XLEN; b++) begin : g_st
      if (STATUS_WMASK[b]) begin : g_rw
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          bit_q <= RST_STATUS[b];
            else if (b == EXL_BIT && take_i)     bit_q <= 1'b1;
            else if (b == EXL_BIT && eret_i)     bit_q <= 1'b0;
            else if (st_wr)                      bit_q <= wr_data_i[b];
         end
         assign status_o[b] = bit_q;
      end else begin : g_ro
         assign status_o[b] = RST_STATUS[b];
      end
   end

   // cause: only the code field is storage
   logic [CODE_W-1:0] code_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      code_q <= '0;
      else if (take_i) code_q <= code_i;
      else if (ca_wr)  code_q <= wr_data_i[CAUSE_LSB +: CODE_W];
   end

   always_comb begin
      cause_o = '0;
      cause_o[CAUSE_LSB +: CODE_W] = code_q;
   end

   // exception PC
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      epc_o <= '0;
      else if (take_i) epc_o <= fault_pc_i;
      else if (ep_wr)  epc_o <= wr_data_i;
   end

endmodule

// File: rtl/exc_read_mux.sv
module exc_read_mux #(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned SEL_W      = 5,
   parameter int unsigned SEL_STATUS = 12,
   parameter int unsigned SEL_CAUSE  = 13,
   parameter int unsigned SEL_EPC    = 14
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [XLEN-1:0]  status_i,
   input  logic [XLEN-1:0]  cause_i,
   input  logic [XLEN-1:0]  epc_i,
   output logic [XLEN-1:0]  data_o
);

   if (SEL_STATUS == SEL_CAUSE || SEL_STATUS == SEL_EPC || SEL_CAUSE == SEL_EPC)
   begin : g_chk_sel
      $error("exc_read_mux: selectors must differ");
   end
   if (SEL_STATUS >= (1 << SEL_W) || SEL_CAUSE >= (1 << SEL_W) || SEL_EPC >= (1 << SEL_W))
   begin : g_chk_range
      $error("exc_read_mux: selector out of range");
   end

   always_comb begin
      data_o = '0;
      if (sel_i == SEL_W'(SEL_STATUS)) data_o = status_i;
      if (sel_i == SEL_W'(SEL_CAUSE))  data_o = cause_i;
      if (sel_i == SEL_W'(SEL_EPC))    data_o = epc_i;
   end

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
   import exc_pkg::*;
#(
   parameter int unsigned     XLEN         = 32,
   parameter int unsigned     SEL_W        = 5,
   parameter int unsigned     SEL_STATUS   = 12,
   parameter int unsigned     SEL_CAUSE    = 13,
   parameter int unsigned     SEL_EPC      = 14,
   parameter logic [XLEN-1:0] HANDLER_PC   = 32'h8000_0180,
   parameter logic [XLEN-1:0] RST_STATUS   = 32'h0000_0002,
   parameter logic [XLEN-1:0] STATUS_WMASK = 32'h0000_0013
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_i,
   input  logic [NSRC-2:0]    exc_req_i,
   input  logic [XLEN-1:0]    fault_pc_i,
   input  logic               eret_i,
   input  logic               mt_en_i,
   input  logic [SEL_W-1:0]   mt_sel_i,
   input  logic [XLEN-1:0]    mt_data_i,
   input  logic [SEL_W-1:0]   mf_sel_i,
   output logic [XLEN-1:0]    mf_data_o,
   output logic               redirect_o,
   output logic [XLEN-1:0]    redirect_pc_o,
   output logic               priv_o
);

   if (HANDLER_PC[1:0] != 2'b00) begin : g_chk_vec
      $error("exc_ctrl_unit: handler address must be word aligned");
   end
   if (!STATUS_WMASK[IE_BIT] || !STATUS_WMASK[UM_BIT]) begin : g_chk_mask
      $error("exc_ctrl_unit: enable and user bits must be storage");
   end

   logic [XLEN-1:0]   status_q, cause_q, epc_q;
   logic [NSRC-1:0]   src;
   logic              irq_ok, take, eret_do;
   logic [CODE_W-1:0] win_code;

   assign irq_ok = irq_i & status_q[IE_BIT] & ~status_q[EXL_BIT];
   assign src    = {exc_req_i, irq_ok};

   exc_prio #(.N(NSRC)) u_prio (
      .req_i  (src),
      .hit_o  (take),
      .code_o (win_code)
   );

   assign eret_do = eret_i & ~take;

   exc_csr_regs #(
      .XLEN         (XLEN),
      .SEL_W        (SEL_W),
      .SEL_STATUS   (SEL_STATUS),
      .SEL_CAUSE    (SEL_CAUSE),
      .SEL_EPC      (SEL_EPC),
      .RST_STATUS   (RST_STATUS),
      .STATUS_WMASK (STATUS_WMASK)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .code_i     (win_code),
      .fault_pc_i (fault_pc_i),
      .eret_i     (eret_do),
      .wr_en_i    (mt_en_i),
      .wr_sel_i   (mt_sel_i),
      .wr_data_i  (mt_data_i),
      .status_o   (status_q),
      .cause_o    (cause_q),
      .epc_o      (epc_q)
   );

   exc_read_mux #(
      .XLEN       (XLEN),
      .SEL_W      (SEL_W),
      .SEL_STATUS (SEL_STATUS),
      .SEL_CAUSE  (SEL_CAUSE),
      .SEL_EPC    (SEL_EPC)
   ) u_rd (
      .sel_i    (mf_sel_i),
      .status_i (status_q),
      .cause_i  (cause_q),
      .epc_i    (epc_q),
      .data_o   (mf_data_o)
   );

   assign redirect_o    = take | eret_do;
   assign redirect_pc_o = take ? HANDLER_PC : epc_q;
   assign priv_o        = status_q[EXL_BIT] | ~status_q[UM_BIT];

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
   parameter int unsigned     XLEN       = 32,
   parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq,
   input logic [4:0]      exc_req,
   input logic [XLEN-1:0] fault_pc,
   input logic            eret,
   input logic            redirect,
   input logic [XLEN-1:0] redirect_pc,
   input logic            priv,
   input logic [XLEN-1:0] status_q,
   input logic [XLEN-1:0] cause_q,
   input logic [XLEN-1:0] epc_q
);

   a_r2_fault_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (|exc_req) |-> (redirect && redirect_pc == HANDLER_PC));

   a_r3_cause_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (|exc_req) |=> (cause_q[1:0] == 2'b00 && cause_q[XLEN-1:7] == '0));

   a_r4_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (|exc_req) |=> (epc_q == $past(fault_pc)));

   a_r5_level_set: assert property (@(posedge clk) disable iff (!rst_n)
      (|exc_req) |=> (status_q[1] && priv));

   a_r6_load_fault_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req[0] && !irq) |=> (cause_q[6:2] == 5'd4));

   a_r7_irq_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && status_q[1] && exc_req == '0 && !eret) |-> !redirect);

   a_r8_return_target: assert property (@(posedge clk) disable iff (!rst_n)
      (eret && exc_req == '0 && !irq) |-> (redirect && redirect_pc == epc_q));

   a_r8_return_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eret && exc_req == '0 && !irq) |=> !status_q[1]);

endmodule

bind exc_ctrl_unit exc_ctrl_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .irq         (irq_i),
   .exc_req     (exc_req_i),
   .fault_pc    (fault_pc_i),
   .eret        (eret_i),
   .redirect    (redirect_o),
   .redirect_pc (redirect_pc_o),
   .priv        (priv_o),
   .status_q    (status_q),
   .cause_q     (cause_q),
   .epc_q       (epc_q)
);

// File: tb/sim_exc_ctrl_unit.sv
module sim_exc_ctrl_unit;

   localparam logic [31:0] VEC = 32'h8000_0180;
   localparam logic [4:0]  S_ST = 5'd12, S_CA = 5'd13, S_EP = 5'd14;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        irq;
   logic [4:0]  req;
   logic [31:0] fpc;
   logic        eret;
   logic        mt_en;
   logic [4:0]  mt_sel;
   logic [31:0] mt_data;
   logic [4:0]  mf_sel;
   logic [31:0] mf_data;
   logic        redirect;
   logic [31:0] redirect_pc;
   logic        priv;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] sm;   // expected status
   logic [31:0] em;   // expected EPC

   always #4 clk = ~clk;

   exc_ctrl_unit u0 (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .exc_req_i(req), .fault_pc_i(fpc),
      .eret_i(eret), .mt_en_i(mt_en), .mt_sel_i(mt_sel), .mt_data_i(mt_data),
      .mf_sel_i(mf_sel), .mf_data_o(mf_data), .redirect_o(redirect),
      .redirect_pc_o(redirect_pc), .priv_o(priv)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clr();
      irq = 0; req = '0; fpc = '0; eret = 0; mt_en = 0; mt_sel = '0; mt_data = '0;
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk); clr();
   endtask

   task automatic rd(input logic [4:0] s, output logic [31:0] d);
      mf_sel = s; #1; d = mf_data;
   endtask

   task automatic wr(input logic [4:0] s, input logic [31:0] d);
      mt_en = 1; mt_sel = s; mt_data = d; tick();
      if (s == S_ST) sm = d & 32'h13;
      if (s == S_EP) em = d;
   endtask

   // present an accepted exception; caller may preset mt_*/eret beforehand
   task automatic raise(input logic iv, input logic [4:0] r, input logic [31:0] pc,
                        input logic [4:0] code, input string tag);
      logic [31:0] d;
      irq = iv; req = r; fpc = pc; #1;
      chk({tag, " R2 redirect"}, {31'd0, redirect}, 32'd1);
      chk({tag, " R2 target"}, redirect_pc, VEC);
      tick();
      sm = sm | 32'h2; em = pc;
      rd(S_CA, d); chk({tag, " R3/R6 cause"}, d, {25'd0, code, 2'b00});
      rd(S_EP, d); chk({tag, " R4 epc"}, d, pc);
      rd(S_ST, d); chk({tag, " R5 status"}, d, sm);
      chk({tag, " R5 priv"}, {31'd0, priv}, 32'd1);
   endtask

   task automatic ret(input string tag);
      logic [31:0] d;
      eret = 1; #1;
      chk({tag, " R8 redirect"}, {31'd0, redirect}, 32'd1);
      chk({tag, " R8 target"}, redirect_pc, em);
      tick();
      sm = sm & ~32'h2;
      rd(S_ST, d); chk({tag, " R8 status"}, d, sm);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(S_ST, d); chk("R1 status", d, 32'h2);
      rd(S_CA, d); chk("R1 cause", d, 32'h0);
      rd(S_EP, d); chk("R1 epc", d, 32'h0);
      chk("R1 priv", {31'd0, priv}, 32'd1);
      chk("R1 redirect", {31'd0, redirect}, 32'd0);
   endtask

   task automatic t_access();
      logic [31:0] d;
      wr(S_ST, 32'hFFFF_FFFF);
      rd(S_ST, d); chk("R9 status mask", d, 32'h13);
      chk("R11 priv exl", {31'd0, priv}, 32'd1);
      wr(S_ST, 32'h11);
      chk("R11 priv user", {31'd0, priv}, 32'd0);
      wr(S_ST, 32'h01);
      chk("R11 priv kernel", {31'd0, priv}, 32'd1);
      wr(S_CA, 32'hFFFF_FFFF);
      rd(S_CA, d); chk("R9 cause mask", d, 32'h7C);
      wr(S_EP, 32'hDEAD_BEEC);
      rd(S_EP, d); chk("R9 epc", d, 32'hDEAD_BEEC);
      rd(5'd3, d); chk("R9 unmapped", d, 32'h0);
      wr(S_ST, 32'h11);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      raise(1'b1, 5'd0, 32'h0040_0100, 5'd0, "irq");
      irq = 1; #1;
      chk("R7 irq under exl", {31'd0, redirect}, 32'd0);
      tick();
      rd(S_CA, d); chk("R7 cause kept", d, 32'h0);
      rd(S_EP, d); chk("R7 epc kept", d, 32'h0040_0100);
      ret("irq");
      chk("R11 back to user", {31'd0, priv}, 32'd0);
   endtask

   task automatic t_irq_disabled();
      logic [31:0] d;
      wr(S_CA, 32'h7C);
      wr(S_ST, 32'h10);
      irq = 1; fpc = 32'h1234; #1;
      chk("R7 irq ie=0", {31'd0, redirect}, 32'd0);
      tick();
      rd(S_CA, d); chk("R7 cause untouched", d, 32'h7C);
      rd(S_ST, d); chk("R7 status untouched", d, 32'h10);
      rd(S_EP, d); chk("R7 epc untouched", d, em);
      wr(S_ST, 32'h11);
   endtask

   task automatic t_faults();
      logic [4:0] codes [5] = '{5'd4, 5'd5, 5'd8, 5'd10, 5'd12};
      for (int i = 0; i < 5; i++) begin
         raise(1'b0, 5'(1 << i), 32'h1000 + 32'(i * 4), codes[i], "fault");
         ret("fault");
      end
   endtask

   task automatic t_prio();
      raise(1'b1, 5'b11111, 32'hA000, 5'd0,  "R6 all");    ret("R6");
      raise(1'b0, 5'b10001, 32'hA004, 5'd4,  "R6 ld+ovf"); ret("R6");
      raise(1'b0, 5'b00110, 32'hA008, 5'd5,  "R6 st+sys"); ret("R6");
      raise(1'b0, 5'b11100, 32'hA00C, 5'd8,  "R6 sys+");   ret("R6");
      raise(1'b0, 5'b11000, 32'hA010, 5'd10, "R6 rsvd+");  ret("R6");
   endtask

   task automatic t_conflict();
      logic [31:0] d;
      mt_en = 1; mt_sel = S_ST; mt_data = 32'h0;
      raise(1'b0, 5'b00001, 32'hB000, 5'd4, "R10 status write");
      ret("R10");
      mt_en = 1; mt_sel = S_EP; mt_data = 32'h55;
      raise(1'b0, 5'b00100, 32'hB004, 5'd8, "R10 epc write");
      mt_en = 1; mt_sel = S_ST; mt_data = 32'h0;
      ret("R10 eret+write");
      chk("R10 priv after dropped write", {31'd0, priv}, 32'd0);
      eret = 1;
      raise(1'b0, 5'b10000, 32'hB008, 5'd12, "R8 eret+fault");
      ret("R8 after clash");
      rd(S_ST, d); chk("R10 final status", d, 32'h11);
   endtask

   initial begin
      #(8 * 20000);
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      clr(); mf_sel = '0; rst_n = 0; sm = 32'h2; em = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_access();
      t_irq();
      t_irq_disabled();
      t_faults();
      t_prio();
      t_conflict();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule